// File: doc/BRIEF.md
# General Register ALU Datapath

This block is the datapath of a small processor. It holds seven 8-bit general registers, two operand multiplexers, a destination decoder and a combinational ALU. A 14-bit control word is applied each clock cycle. The word picks two operand sources, one ALU operation and one destination. The ALU result is visible on an output port in the same cycle. On the next rising clock edge it is written into the chosen register, or into none.

Either operand can come from an external data input instead of a register, which is how values enter the register file. Choosing no destination turns a control word into a pure read or compute step. The result port then shows the outcome and no register is touched. All ports are plain control and data pins. The block takes one control word per cycle, so there is no handshake and no back-pressure.

Top module: `gra_datapath`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, every register is cleared to 0x00, and it reads back 0x00 after reset is released.
- R2: Control word layout: bits [13:11] pick operand A, bits [10:8] pick operand B, bits [7:5] pick the destination, and bits [4:0] give the operation code.
- R3: An operand select of 1 to 7 routes register R1 to R7 to that operand; a select of 0 routes `ext_in`.
- R4: `alu_y` shows the ALU result for the current control word combinationally. On the rising clock edge, the register named by a non-zero destination field loads that result.
- R5: A destination field of 0 writes no register, while `alu_y` still shows the result.
- R6: A register that is not the destination keeps its value across the clock edge.
- R7: Arithmetic codes wrap modulo 256: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1.
- R8: Logic codes are bitwise: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A.
- R9: Code 10000 shifts A right by one and code 11000 shifts A left by one. Both are logical shifts and fill the vacated bit with 0.
- R10: Every operation code not listed in R7 to R9 gives a result of 0x00.
- R11: The control word with A select 2, B select 3, destination 1 and operation 00101 leaves R2 minus R3 in R1.
- R12: A register that is both a source and the destination feeds its old value to the ALU. For example, A select 4, destination 4 and operation 11000 replaces R4 with R4 shifted left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Operand selects, destination select and operation code |
| ext_in | input | 8 | External operand, used when an operand select is 0 |
| alu_y | output | 8 | Combinational ALU result for the current control word |

## Verification
Reading a register and writing the same register can fall in the same cycle. This is the R12 case, where the destination is also a source. Directed words such as the in-place left shift of R4 provoke it, and so do random words whose destination equals an operand select. The bench judges it by reading the register back afterwards and comparing against a model that uses the pre-edge value. It also checks that the other six registers kept their values.

// File: rtl/gra_pkg.sv
package gra_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
  localparam logic [OP_W-1:0] OP_INC  = 5'b00001;
  localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
  localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
  localparam logic [OP_W-1:0] OP_DEC  = 5'b00110;
  localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
  localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
  localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
  localparam logic [OP_W-1:0] OP_NOT  = 5'b01110;
  localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
  localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return (op == OP_PASS) || (op == OP_INC) || (op == OP_ADD) ||
           (op == OP_SUB)  || (op == OP_DEC) || (op == OP_AND) ||
           (op == OP_OR)   || (op == OP_XOR) || (op == OP_NOT) ||
           (op == OP_SHR)  || (op == OP_SHL);
  endfunction
endpackage

// File: rtl/gra_alu.sv
module gra_alu
  import gra_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (op)
      OP_PASS: y = a;
      OP_INC:  y = a + ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DEC:  y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  y = {1'b0, a[DATA_W-1:1]};
      OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/gra_regfile.sv
module gra_regfile #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SEL_W-1:0]               sel_a,
  input  logic [SEL_W-1:0]               sel_b,
  input  logic [SEL_W-1:0]               sel_d,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [DATA_W-1:0]              ext_in,
  output logic [DATA_W-1:0]              opnd_a,
  output logic [DATA_W-1:0]              opnd_b,
  output logic [((1<<SEL_W)-1)*DATA_W-1:0] regs_flat
);
  localparam int NUM_REGS = (1 << SEL_W) - 1;

  // destination decoder: code 0 enables nothing
  logic [NUM_REGS:1] load_en;

  for (genvar i = 1; i <= NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign load_en[i] = (sel_d == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (load_en[i]) q <= wr_data;
    end
    assign regs_flat[(i-1)*DATA_W +: DATA_W] = q;
  end

  // source multiplexers: code 0 picks the external input
  always_comb begin
    opnd_a = ext_in;
    opnd_b = ext_in;
    for (int k = 1; k <= NUM_REGS; k++) begin
      if (sel_a == SEL_W'(k)) opnd_a = regs_flat[(k-1)*DATA_W +: DATA_W];
      if (sel_b == SEL_W'(k)) opnd_b = regs_flat[(k-1)*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/gra_datapath.sv
module gra_datapath
  import gra_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int CW_W   = 3*SEL_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] alu_y
);
  localparam int NUM_REGS = (1 << SEL_W) - 1;
  localparam int A_LSB    = OP_W + 2*SEL_W;
  localparam int B_LSB    = OP_W + SEL_W;
  localparam int D_LSB    = OP_W;

  logic [SEL_W-1:0]           sel_a, sel_b, sel_d;
  logic [OP_W-1:0]            op;
  logic [DATA_W-1:0]          opnd_a, opnd_b;
  logic [NUM_REGS*DATA_W-1:0] reg_snapshot;

  assign sel_a = ctrl_word[A_LSB +: SEL_W];
  assign sel_b = ctrl_word[B_LSB +: SEL_W];
  assign sel_d = ctrl_word[D_LSB +: SEL_W];
  assign op    = ctrl_word[0 +: OP_W];

  gra_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d),
    .wr_data(alu_y), .ext_in(ext_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .regs_flat(reg_snapshot)
  );

  gra_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(opnd_a), .b(opnd_b), .y(alu_y)
  );
endmodule

// File: rtl/gra_datapath_chk.sv
module gra_datapath_chk
  import gra_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int CW_W   = 3*SEL_W + OP_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [CW_W-1:0]                  ctrl_word,
  input logic [DATA_W-1:0]                ext_in,
  input logic [DATA_W-1:0]                alu_y,
  input logic [((1<<SEL_W)-1)*DATA_W-1:0] reg_snapshot
);
  localparam int NUM_REGS = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] c_a, c_d;
  logic [OP_W-1:0]  c_op;
  assign c_a  = ctrl_word[OP_W+2*SEL_W +: SEL_W];
  assign c_d  = ctrl_word[OP_W +: SEL_W];
  assign c_op = ctrl_word[0 +: OP_W];

  function automatic logic [DATA_W-1:0] reg_at(
      input logic [NUM_REGS*DATA_W-1:0] snap, input logic [SEL_W-1:0] idx);
    logic [DATA_W-1:0] v = '0;
    for (int k = 1; k <= NUM_REGS; k++)
      if (idx == SEL_W'(k)) v = snap[(k-1)*DATA_W +: DATA_W];
    return v;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (reg_snapshot == '0));

  assert_ext_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_a == '0 && c_op == OP_PASS) |-> (alu_y == ext_in));

  assert_dest_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_d != '0) |=> (reg_at(reg_snapshot, $past(c_d)) == $past(alu_y)));

  assert_null_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_d == '0) |=> $stable(reg_snapshot));

  for (genvar i = 1; i <= NUM_REGS; i++) begin : g_hold
    assert_others_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_d != SEL_W'(i)) |=> $stable(reg_snapshot[(i-1)*DATA_W +: DATA_W]));
  end

  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_defined(c_op) |-> (alu_y == '0));
endmodule

bind gra_datapath gra_datapath_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CW_W(CW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
  .alu_y(alu_y), .reg_snapshot(reg_snapshot)
);

// File: tb/gra_datapath_test.sv
`timescale 1ns/1ps
module gra_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  alu_y;

  int total = 0;
  int bad = 0;
  logic [7:0] model [1:7];

  gra_datapath uut (.clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
                    .ext_in(ext_in), .alu_y(alu_y));

  always #4 clk = ~clk;

  function automatic logic [7:0] ref_alu(input logic [4:0] op,
                                         input logic [7:0] a, input logic [7:0] b);
    case (op)
      5'b00000: return a;
      5'b00001: return a + 8'd1;
      5'b00010: return a + b;
      5'b00101: return a - b;
      5'b00110: return a - 8'd1;
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return a >> 1;
      5'b11000: return a << 1;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R7";
      5'b01000, 5'b01010, 5'b01100, 5'b01110:           return "R8";
      5'b10000, 5'b11000:                               return "R9";
      default:                                          return "R10";
    endcase
  endfunction

  function automatic logic [7:0] src(input logic [2:0] s, input logic [7:0] ext);
    return (s == 3'd0) ? ext : model[s];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one control word: drive after the falling edge, check alu_y, then let the edge commit
  task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                      input logic [4:0] op, input logic [7:0] ext, input string req);
    logic [7:0] exp;
    @(negedge clk);
    ctrl_word = {sa, sb, sd, op};   // R2 field layout
    ext_in = ext;
    exp = ref_alu(op, src(sa, ext), src(sb, ext));
    #1;
    check(req, alu_y, exp);
    @(posedge clk);
    if (sd != 3'd0) model[sd] = exp;
  endtask

  task automatic read_all(input string req);
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      ctrl_word = {3'(i), 3'd0, 3'd0, 5'b00000};
      ext_in = 8'hC3;
      #1;
      check(req, alu_y, model[i]);
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 1; i <= 7; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    read_all("R1");

    // R3: load through the external operand
    step(3'd0, 3'd0, 3'd2, 5'b00000, 8'h5A, "R3");
    step(3'd0, 3'd0, 3'd3, 5'b00000, 8'h7F, "R3");
    step(3'd0, 3'd0, 3'd4, 5'b00000, 8'h81, "R3");
    // R11: R1 <- R2 - R3 = 0x5A - 0x7F = 0xDB
    step(3'd2, 3'd3, 3'd1, 5'b00101, 8'h00, "R11");
    check("R11", model[1], 8'hDB);
    // R12: R4 <- shl R4, 0x81 -> 0x02
    step(3'd4, 3'd0, 3'd4, 5'b11000, 8'hFF, "R12");
    check("R12", model[4], 8'h02);
    read_all("R6");
    // R5: no destination, result still visible, registers unchanged
    step(3'd2, 3'd3, 3'd0, 5'b00010, 8'h00, "R5");
    read_all("R5");
    // R7 wrap cases, R9 shifts, R10 undefined code
    step(3'd0, 3'd0, 3'd5, 5'b00001, 8'hFF, "R7");
    step(3'd0, 3'd0, 3'd6, 5'b00110, 8'h00, "R7");
    step(3'd0, 3'd0, 3'd7, 5'b10000, 8'h81, "R9");
    step(3'd7, 3'd0, 3'd0, 5'b00011, 8'h00, "R10");
    read_all("R4");
    check("R7", model[5], 8'h00);
    check("R7", model[6], 8'hFF);
    check("R9", model[7], 8'h40);

    // random words, mostly legal codes
    for (int n = 0; n < 400; n++) begin
      logic [4:0] op;
      logic [4:0] legal [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                                 5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};
      logic [2:0] sa, sb, sd;
      sa = 3'($urandom_range(0, 7));
      sb = 3'($urandom_range(0, 7));
      sd = ($urandom_range(0, 3) == 0) ? sa : 3'($urandom_range(0, 7));  // R12 overlap
      op = ($urandom_range(0, 7) == 0) ? 5'($urandom) : legal[$urandom_range(0, 10)];
      step(sa, sb, sd, op, 8'($urandom), tag_of(op));
      if (n % 50 == 49) read_all("R6");
    end
    read_all("R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule